// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a sum-of-products logic device. It takes the OR-array sum for its output and the per-cell output-enable product term. It also takes the two device-wide terms that control every register: a synchronous set and an asynchronous clear. From these it produces a pin value and a tri-state enable, and it returns one selected signal to the logic array as feedback.

A four-bit configuration word sets the cell's behaviour:

- Bit 0 chooses the output type. A 1 sends the sum through a D flip-flop (registered). A 0 passes the sum straight through (combinational).
- Bit 1 selects active-low output. The inversion is applied after the type choice.
- Bits 3:2 choose the feedback source. 00 selects the true register state, 01 selects the raw OR-array sum, and 10 or 11 select the value read back from the pin.

The pin is modelled as a driven value, an enable and a separate read-back input.

The register also has a synchronous active-low reset for the surrounding chip. The asynchronous clear overrides every other control of the register. The reset comes next, then the preset, then normal data capture.

Top module: `oc_macrocell`

## Requirements
- R1: With cfg[0]=1 the register captures `sum_in` on each rising `clk` edge, and `pin_out` changes only after that edge.
- R2: With cfg[0]=0, `pin_out` follows `sum_in` (XOR cfg[1]) with no clock edge needed.
- R3: With cfg[1]=1, `pin_out` is the inverse of the selected value. A cleared register in registered active-low mode therefore drives `pin_out`=1.
- R4: When `preset_term` is high at a rising edge, the register becomes 1 at that edge and not before.
- R5: When `clear_term` goes high, the register goes to 0 at once, between clock edges. It stays 0 at every edge while `clear_term` is held high.
- R6: When `preset_term` and `clear_term` are both high, the register stays 0. Once the clear is released, the preset sets the register at the next edge.
- R7: `pin_oe` equals `oe_term` at all times, and `oe_term` has no effect on the value of `pin_out`.
- R8: `fb_out` is selected by cfg[3:2]:
  - 00 gives the register state without polarity applied.
  - 01 gives `sum_in`.
  - 10 and 11 give `pin_in`.
- R9: When `rst_n` is low at a rising edge and `clear_term` is low, the register becomes 0 even if `preset_term` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| cfg | input | 4 | Configuration: [0] registered, [1] active low, [3:2] feedback select |
| sum_in | input | 1 | OR-array sum for this cell |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous set term |
| clear_term | input | 1 | Global asynchronous clear term |
| pin_in | input | 1 | Value read back from the pin |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb_out | output | 1 | Feedback returned to the logic array |

## Verification
The set and the clear can both be true in the same cycle. The bench raises both terms together ahead of an edge and expects the register to read 0 after that edge. It then drops only the clear and expects a 1 one edge later, which shows that the preset was held off rather than lost. The asynchronous side is checked separately. The register is first set to 1, then the clear is raised midway between edges and the pin is sampled before the next rising edge.

// File: rtl/oc_pkg.sv
// Package: shared configuration types for the output macrocell.
// Assumes the four-bit configuration word is packed as {fb_sel, act_low, reg_mode}.
package oc_pkg;

    // Feedback source selection, cfg[3:2].
    typedef enum logic [1:0] {
        FB_REG     = 2'b00,
        FB_COMB    = 2'b01,
        FB_PIN     = 2'b10,
        FB_PIN_ALT = 2'b11
    } fb_sel_e;

    // Decoded view of the configuration word, MSB first.
    typedef struct packed {
        fb_sel_e fb_sel;
        logic    act_low;
        logic    reg_mode;
    } cell_cfg_t;

endpackage

// File: rtl/oc_dff.sv
// Module: the cell's state flip-flop.
// Priority: asynchronous clear, then synchronous reset, then synchronous set, then data.
// Assumes async_clr is a level: while it stays high the state is held at 0.
module oc_dff (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic sync_set,
    input  logic async_clr,
    output logic q
);

    // State update with the clear acting outside the clock.
    always_ff @(posedge clk or posedge async_clr) begin
        if (async_clr)
            q <= 1'b0;
        else if (!rst_n)
            q <= 1'b0;
        else if (sync_set)
            q <= 1'b1;
        else
            q <= d;
    end

    // R1: with no set and no clear, the next state is the data seen at the edge.
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
        !sync_set |=> (q == $past(d)));

    // R4: the set takes effect at the edge that samples it.
    a_r4_preset: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
        sync_set |=> q);

    // R5: a held clear keeps the state low at every edge.
    a_r5_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
        async_clr |-> !q);

    // R6: when set and clear meet, the clear wins.
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_set && async_clr) |-> !q);

    // R9: reset overrides the set.
    a_r9_reset: assert property (@(posedge clk) disable iff (async_clr)
        !rst_n |=> !q);

endmodule

// File: rtl/oc_out_sel.sv
// Module: output value path.
// Picks register or raw sum, then applies the polarity inversion.
// Assumes the selection is made before inversion, so the inversion acts on either source.
module oc_out_sel (
    input  logic reg_mode,
    input  logic act_low,
    input  logic q,
    input  logic sum,
    output logic out_val
);

    logic picked;

    // Type select, then polarity.
    always_comb begin
        picked  = reg_mode ? q : sum;
        out_val = picked ^ act_low;
    end

endmodule

// File: rtl/oc_fb_sel.sv
// Module: feedback selector returning one signal to the logic array.
// Assumes the register source is taken before polarity, and both upper codes select the pin.
module oc_fb_sel
    import oc_pkg::*;
(
    input  fb_sel_e sel,
    input  logic    q,
    input  logic    sum,
    input  logic    pin,
    output logic    fb
);

    // Three-way choice of the feedback source.
    always_comb begin
        unique case (sel)
            FB_REG:     fb = q;
            FB_COMB:    fb = sum;
            FB_PIN,
            FB_PIN_ALT: fb = pin;
            default:    fb = pin;
        endcase
    end

endmodule

// File: rtl/oc_macrocell.sv
// Module: top of the configurable output macrocell.
// Links the state flop, the output path and the feedback selector under one configuration word.
// Assumes the pad is outside this block: the pin is given as a value, an enable and a read-back.
module oc_macrocell
    import oc_pkg::*;
#(
    parameter int CFG_W = $bits(cell_cfg_t)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             sum_in,
    input  logic             oe_term,
    input  logic             preset_term,
    input  logic             clear_term,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb_out
);

    cell_cfg_t cfg_d;
    logic      q_w;

    // Decode the configuration word.
    always_comb cfg_d = cell_cfg_t'(cfg);

    oc_dff u_dff (
        .clk       (clk),
        .rst_n     (rst_n),
        .d         (sum_in),
        .sync_set  (preset_term),
        .async_clr (clear_term),
        .q         (q_w)
    );

    oc_out_sel u_out (
        .reg_mode (cfg_d.reg_mode),
        .act_low  (cfg_d.act_low),
        .q        (q_w),
        .sum      (sum_in),
        .out_val  (pin_out)
    );

    oc_fb_sel u_fb (
        .sel (cfg_d.fb_sel),
        .q   (q_w),
        .sum (sum_in),
        .pin (pin_in),
        .fb  (fb_out)
    );

    // Driver enable follows the product term.
    always_comb pin_oe = oe_term;

    // R2: combinational mode tracks the sum with polarity.
    a_r2_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[0] |-> (pin_out == (sum_in ^ cfg[1])));

    // R3: registered active-low drives the inverse of the state.
    a_r3_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[0] && cfg[1]) |-> (pin_out == !q_w));

    // R8: the upper feedback codes return the pin.
    a_r8_fb_pin: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[3] |-> (fb_out == pin_in));

    // R8: code 00 returns the state before polarity.
    a_r8_fb_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[3:2] == 2'b00) |-> (fb_out == q_w));

endmodule

// File: tb/oc_macrocell_tb_top.sv
module oc_macrocell_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg = 4'b0001;
    logic       sum_in = 1'b0;
    logic       oe_term = 1'b0;
    logic       preset_term = 1'b0;
    logic       clear_term = 1'b0;
    logic       pin_in = 1'b0;
    logic       pin_out;
    logic       pin_oe;
    logic       fb_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    oc_macrocell dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .sum_in      (sum_in),
        .oe_term     (oe_term),
        .preset_term (preset_term),
        .clear_term  (clear_term),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .fb_out      (fb_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reset state; R9 reset beats preset.
    task automatic t_reset();
        rst_n = 1'b0;
        preset_term = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 reset over preset", pin_out, 1'b0);
        chk("R8 reset fb reg", fb_out, 1'b0);
        preset_term = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1 registered capture.
    task automatic t_capture();
        cfg = 4'b0001;
        sum_in = 1'b1;
        #1;
        chk("R1 no change before edge", pin_out, 1'b0);
        @(negedge clk);
        chk("R1 captured 1", pin_out, 1'b1);
        sum_in = 1'b0;
        @(negedge clk);
        chk("R1 captured 0", pin_out, 1'b0);
    endtask

    // R2 combinational path.
    task automatic t_comb();
        cfg = 4'b0000;
        sum_in = 1'b1;
        #1;
        chk("R2 comb high", pin_out, 1'b1);
        sum_in = 1'b0;
        #1;
        chk("R2 comb low", pin_out, 1'b0);
        @(negedge clk);
    endtask

    // R3 polarity.
    task automatic t_polarity();
        cfg = 4'b0010;
        sum_in = 1'b1;
        #1;
        chk("R3 comb active low", pin_out, 1'b0);
        sum_in = 1'b0;
        cfg = 4'b0011;
        clear_term = 1'b1;
        #1;
        clear_term = 1'b0;
        #1;
        chk("R3 cleared reg active low drives high", pin_out, 1'b1);
        @(negedge clk);
    endtask

    // R4 synchronous preset.
    task automatic t_preset();
        cfg = 4'b0001;
        sum_in = 1'b0;
        preset_term = 1'b1;
        #1;
        chk("R4 preset not before edge", pin_out, 1'b0);
        @(negedge clk);
        chk("R4 preset at edge", pin_out, 1'b1);
        preset_term = 1'b0;
        @(negedge clk);
        chk("R4 preset released", pin_out, 1'b0);
    endtask

    // R5 asynchronous clear between edges.
    task automatic t_async_clear();
        cfg = 4'b0001;
        preset_term = 1'b1;
        @(negedge clk);
        preset_term = 1'b0;
        sum_in = 1'b1;
        @(negedge clk);
        chk("R5 setup high", pin_out, 1'b1);
        #1;
        clear_term = 1'b1;
        #1;
        chk("R5 clear between edges", pin_out, 1'b0);
        @(negedge clk);
        chk("R5 clear held over edge", pin_out, 1'b0);
        clear_term = 1'b0;
        @(negedge clk);
        chk("R5 capture after release", pin_out, 1'b1);
        sum_in = 1'b0;
        @(negedge clk);
    endtask

    // R6 clear over preset.
    task automatic t_priority();
        cfg = 4'b0001;
        sum_in = 1'b0;
        preset_term = 1'b1;
        clear_term = 1'b1;
        @(negedge clk);
        chk("R6 clear beats preset", pin_out, 1'b0);
        clear_term = 1'b0;
        @(negedge clk);
        chk("R6 preset after release", pin_out, 1'b1);
        preset_term = 1'b0;
        @(negedge clk);
    endtask

    // R7 output enable.
    task automatic t_oe();
        cfg = 4'b0000;
        sum_in = 1'b1;
        oe_term = 1'b0;
        #1;
        chk("R7 disabled", pin_oe, 1'b0);
        chk("R7 value kept while disabled", pin_out, 1'b1);
        oe_term = 1'b1;
        #1;
        chk("R7 enabled", pin_oe, 1'b1);
        chk("R7 value kept while enabled", pin_out, 1'b1);
        sum_in = 1'b0;
        oe_term = 1'b0;
        @(negedge clk);
    endtask

    // R8 feedback selection.
    task automatic t_feedback();
        cfg = 4'b0011;
        sum_in = 1'b1;
        @(negedge clk);
        sum_in = 1'b0;
        #1;
        chk("R8 fb reg true polarity", fb_out, 1'b1);
        chk("R3 pin inverted", pin_out, 1'b0);
        cfg = 4'b0111;
        #1;
        chk("R8 fb comb low", fb_out, 1'b0);
        sum_in = 1'b1;
        #1;
        chk("R8 fb comb high", fb_out, 1'b1);
        cfg = 4'b1011;
        pin_in = 1'b1;
        #1;
        chk("R8 fb pin high", fb_out, 1'b1);
        pin_in = 1'b0;
        #1;
        chk("R8 fb pin low", fb_out, 1'b0);
        cfg = 4'b1111;
        pin_in = 1'b1;
        #1;
        chk("R8 fb code 11 pin", fb_out, 1'b1);
        sum_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_capture();
        t_comb();
        t_polarity();
        t_preset();
        t_async_clear();
        t_priority();
        t_oe();
        t_feedback();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule